// File: doc/BRIEF.md
# Accumulator Phase Detector with PI and IIR Loop Filter

This block is the digital heart of a phase-domain PLL that has no feedback divider. It runs entirely on the retimed reference clock, which is the only clock in the block. On every reference edge a reference phase register advances by the frequency command word. The same edge samples the integer count of oscillator edges and the fractional oscillator phase reported by a time-to-digital converter. The difference of the two phases is the phase error.

The phase error passes through a proportional path and an optional integrator, which switch the loop between type-I and type-II. A cascade of first-order IIR smoothing stages follows. The last stage drives a saturating oscillator tuning word centred at mid-scale. Gains and smoothing strengths are right shifts by powers of two, so the datapath has no multipliers.

In lock the oscillator phase grows by the command word on each reference period, so the output frequency equals the reference frequency times the command word. The error is then zero and the tuning word holds still. The oscillator, the converter circuit and the clock retiming sit outside this block.

Top module: `phase_loop_core`

## Requirements
- R1: A synchronous active-high reset clears the reference phase, the phase error, the integrator and every filter stage. After reset `phase_err_o` reads 0 and `otw_o` reads the mid-scale code 2048.
- R2: The reference phase is unsigned, with 8 integer and 16 fractional bits. On each clock edge with reset low it grows by `fcw_i`, modulo 2^24. The same edge registers `phase_err_o` as the new reference phase minus the sampled oscillator phase, taken as a signed 24-bit number.
- R3: The sampled oscillator phase is `{osc_cnt_i, tdc_code_i, 10'b0}`. The 6-bit converter code spans one oscillator period and is scaled to 16 fractional bits by a left shift of 10.
- R4: The integer part of both phases wraps modulo 256. A loop that tracks the reference keeps a zero error while the phases cross the wrap point.
- R5: When `int_en_i` is low, the integrator is held at zero and the filter output is the phase error arithmetically shifted right by `kp_shift_i`. This is type-I operation.
- R6: When `int_en_i` is high, each edge adds the phase error shifted right by `ki_shift_i` to a 32-bit integrator. The integrator saturates and never wraps. The filter output is the saturated sum of the proportional term and the new integrator value.
- R7: There are two IIR stages. When `iir_en_i` is high, each stage moves toward its input by (input − state) shifted right by `iir_shift_i`. When `iir_en_i` is low, each stage copies its input. Either way each stage adds one register.
- R8: `otw_o` is 2048 plus the last IIR stage shifted right by 8, clamped to 0..4095. An input change reaches `phase_err_o` after 1 edge and `otw_o` after 4 edges.
- R9: When the oscillator phase sampled at edge k equals k times `fcw_i`, the phase error stays 0 and `otw_o` stays at 2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Retimed reference clock, the master clock |
| rst | input | 1 | Synchronous reset, active high |
| fcw_i | input | 24 | Frequency command word, 8.16 unsigned |
| osc_cnt_i | input | 8 | Integer count of oscillator edges |
| tdc_code_i | input | 6 | Fractional oscillator phase code |
| kp_shift_i | input | 4 | Proportional gain as right shift |
| ki_shift_i | input | 4 | Integral gain as right shift |
| int_en_i | input | 1 | Enables the integrator (type-II) |
| iir_en_i | input | 1 | Enables IIR smoothing |
| iir_shift_i | input | 3 | IIR strength as right shift |
| phase_err_o | output | 24 | Signed registered phase error |
| otw_o | output | 12 | Saturated oscillator tuning word |

## Verification
The phase error is due at the first rising edge that sees a stimulus. The tuning word is due four edges later: one edge for the detector, one for the loop filter and one for each of the two IIR stages. The bench changes inputs only on falling edges and compares each output on the falling edge after every rising edge. Its reference model advances each pipeline stage once per edge, using the previous stage's old value. A directed sequence confirms that the tuning word holds at mid-scale for three edges and moves exactly on the fourth.

// File: rtl/pll_pd_pkg.sv
package pll_pd_pkg;

    localparam int PH_INT_W  = 8;
    localparam int PH_FRAC_W = 16;
    localparam int PH_W      = PH_INT_W + PH_FRAC_W;
    localparam int LF_W      = 32;

    typedef logic        [PH_W-1:0] phase_t;
    typedef logic signed [PH_W-1:0] perr_t;
    typedef logic signed [LF_W-1:0] lf_t;
    typedef logic signed [LF_W:0]   lf_wide_t;

    typedef struct packed {
        logic [3:0] kp_sh;
        logic [3:0] ki_sh;
        logic       int_en;
    } lf_cfg_t;

    function automatic lf_t sat_lf(input lf_wide_t v);
        lf_wide_t hi;
        lf_wide_t lo;
        hi = {2'b00, {(LF_W-1){1'b1}}};
        lo = {2'b11, {(LF_W-1){1'b0}}};
        if (v > hi)
            return {1'b0, {(LF_W-1){1'b1}}};
        else if (v < lo)
            return {1'b1, {(LF_W-1){1'b0}}};
        else
            return v[LF_W-1:0];
    endfunction

    function automatic lf_wide_t widen(input lf_t v);
        return {v[LF_W-1], v};
    endfunction

endpackage

// File: rtl/pd_phase_acc.sv
module pd_phase_acc
    import pll_pd_pkg::*;
#(
    parameter int TDC_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  phase_t              fcw_i,
    input  logic [PH_INT_W-1:0] osc_cnt_i,
    input  logic [TDC_W-1:0]    tdc_i,
    output perr_t               perr_o
);
    phase_t                 ref_q;
    phase_t                 ref_next;
    phase_t                 osc_ph;
    logic [PH_FRAC_W-1:0]   frac_norm;

    generate
        if (TDC_W >= PH_FRAC_W) begin : g_trunc
            assign frac_norm = tdc_i[TDC_W-1 -: PH_FRAC_W];
        end else begin : g_shift
            assign frac_norm = {tdc_i, {(PH_FRAC_W-TDC_W){1'b0}}};
        end
    endgenerate

    assign ref_next = ref_q + fcw_i;
    assign osc_ph   = {osc_cnt_i, frac_norm};

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q  <= '0;
            perr_o <= '0;
        end else begin
            ref_q  <= ref_next;
            perr_o <= perr_t'(ref_next - osc_ph);
        end
    end

    // R2: reference phase steps by the command word of the previous cycle
    p_ref_advance_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (ref_q == phase_t'($past(ref_q) + $past(fcw_i))));

endmodule

// File: rtl/pd_loop_filter.sv
module pd_loop_filter
    import pll_pd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  perr_t   perr_i,
    input  lf_cfg_t cfg_i,
    output lf_t     lf_o
);
    lf_t e_ext;
    lf_t prop;
    lf_t inc;
    lf_t isum;
    lf_t integ_q;

    assign e_ext = {{(LF_W-PH_W){perr_i[PH_W-1]}}, perr_i};
    assign prop  = e_ext >>> cfg_i.kp_sh;
    assign inc   = e_ext >>> cfg_i.ki_sh;
    assign isum  = sat_lf(widen(integ_q) + widen(inc));

    always_ff @(posedge clk) begin
        if (rst) begin
            integ_q <= '0;
            lf_o    <= '0;
        end else if (cfg_i.int_en) begin
            integ_q <= isum;
            lf_o    <= sat_lf(widen(prop) + widen(isum));
        end else begin
            integ_q <= '0;
            lf_o    <= prop;
        end
    end

    // R6: a non-negative error never lowers the saturating integrator
    p_integ_rise_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.int_en && !perr_i[PH_W-1]) |=> (integ_q >= $past(integ_q)));

endmodule

// File: rtl/pd_iir_stage.sv
module pd_iir_stage
    import pll_pd_pkg::*;
#(
    parameter int SH_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en_i,
    input  logic [SH_W-1:0] sh_i,
    input  lf_t             x_i,
    output lf_t             y_o
);
    lf_wide_t diff;
    lf_wide_t step;

    assign diff = widen(x_i) - widen(y_o);
    assign step = diff >>> sh_i;

    always_ff @(posedge clk) begin
        if (rst)
            y_o <= '0;
        else if (en_i)
            y_o <= y_o + step[LF_W-1:0];
        else
            y_o <= x_i;
    end

    // R7: a smoothing step lands between the old state and the old input
    p_iir_between_r7: assert property (@(posedge clk) disable iff (rst)
        en_i |=> (((y_o >= $past(x_i)) && (y_o <= $past(y_o))) ||
                  ((y_o <= $past(x_i)) && (y_o >= $past(y_o)))));

    // R7: bypassed stage copies its input
    p_iir_bypass_r7: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (y_o == $past(x_i)));

endmodule

// File: rtl/phase_loop_core.sv
module phase_loop_core
    import pll_pd_pkg::*;
#(
    parameter int TDC_W      = 6,
    parameter int GAIN_SH_W  = 4,
    parameter int IIR_SH_W   = 3,
    parameter int IIR_STAGES = 2,
    parameter int OTW_W      = 12,
    parameter int OTW_SHIFT  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PH_W-1:0]      fcw_i,
    input  logic [PH_INT_W-1:0]  osc_cnt_i,
    input  logic [TDC_W-1:0]     tdc_code_i,
    input  logic [GAIN_SH_W-1:0] kp_shift_i,
    input  logic [GAIN_SH_W-1:0] ki_shift_i,
    input  logic                 int_en_i,
    input  logic                 iir_en_i,
    input  logic [IIR_SH_W-1:0]  iir_shift_i,
    output logic [PH_W-1:0]      phase_err_o,
    output logic [OTW_W-1:0]     otw_o
);
    localparam int  CENTER  = 2 ** (OTW_W - 1);
    localparam int  TOP     = 2 ** OTW_W - 1;
    localparam lf_t HI_THR  = lf_t'(CENTER * (2 ** OTW_SHIFT));
    localparam lf_t LO_THR  = -HI_THR;

    perr_t    perr;
    lf_cfg_t  cfg;
    lf_t      chain [IIR_STAGES+1];
    lf_t      iir_last;
    lf_t      scaled;
    lf_wide_t total;

    assign cfg.kp_sh  = kp_shift_i;
    assign cfg.ki_sh  = ki_shift_i;
    assign cfg.int_en = int_en_i;

    pd_phase_acc #(.TDC_W(TDC_W)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .fcw_i     (fcw_i),
        .osc_cnt_i (osc_cnt_i),
        .tdc_i     (tdc_code_i),
        .perr_o    (perr)
    );

    pd_loop_filter u_lf (
        .clk    (clk),
        .rst    (rst),
        .perr_i (perr),
        .cfg_i  (cfg),
        .lf_o   (chain[0])
    );

    generate
        for (genvar s = 0; s < IIR_STAGES; s++) begin : g_iir
            pd_iir_stage #(.SH_W(IIR_SH_W)) u_stage (
                .clk  (clk),
                .rst  (rst),
                .en_i (iir_en_i),
                .sh_i (iir_shift_i),
                .x_i  (chain[s]),
                .y_o  (chain[s+1])
            );
        end
    endgenerate

    assign iir_last    = chain[IIR_STAGES];
    assign scaled      = iir_last >>> OTW_SHIFT;
    assign total       = widen(scaled) + $signed((LF_W+1)'(CENTER));
    assign phase_err_o = perr;

    always_comb begin
        if (total < $signed((LF_W+1)'(0)))
            otw_o = '0;
        else if (total > $signed((LF_W+1)'(TOP)))
            otw_o = '1;
        else
            otw_o = total[OTW_W-1:0];
    end

    // R8: large positive filter state pins the tuning word at full scale
    p_otw_top_r8: assert property (@(posedge clk) disable iff (rst)
        (iir_last > HI_THR) |-> (otw_o == {OTW_W{1'b1}}));

    // R8: large negative filter state pins the tuning word at zero
    p_otw_floor_r8: assert property (@(posedge clk) disable iff (rst)
        (iir_last < LO_THR) |-> (otw_o == '0));

endmodule

// File: tb/phase_loop_core_tb_top.sv
`timescale 1ns/1ps
module phase_loop_core_tb_top;

    localparam longint MASK = 64'hFFFFFF;

    typedef struct packed {
        logic [23:0] fcw;
        logic [3:0]  kp;
        logic [3:0]  ki;
        logic        ie;
        logic        ee;
        logic [2:0]  sh;
        logic [23:0] lag;
        logic [9:0]  steps;
    } row_t;

    localparam int NROWS = 6;
    localparam row_t ROWS [NROWS] = '{
        '{24'h0A8000, 4'd2, 4'd6, 1'b1, 1'b1, 3'd2, 24'h000000, 10'd40},
        '{24'h0A8000, 4'd3, 4'd8, 1'b0, 1'b0, 3'd0, 24'h004000, 10'd12},
        '{24'h073400, 4'd1, 4'd7, 1'b1, 1'b1, 3'd1, 24'hFFC000, 10'd30},
        '{24'h123456, 4'd4, 4'd5, 1'b1, 1'b1, 3'd3, 24'h001234, 10'd30},
        '{24'h0A8000, 4'd0, 4'd0, 1'b1, 1'b0, 3'd0, 24'h7F0000, 10'd300},
        '{24'h0A8000, 4'd0, 4'd0, 1'b1, 1'b1, 3'd2, 24'h810000, 10'd300}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] fcw_i = '0;
    logic [7:0]  osc_cnt_i = '0;
    logic [5:0]  tdc_code_i = '0;
    logic [3:0]  kp_shift_i = '0;
    logic [3:0]  ki_shift_i = '0;
    logic        int_en_i = 1'b0;
    logic        iir_en_i = 1'b0;
    logic [2:0]  iir_shift_i = '0;
    logic [23:0] phase_err_o;
    logic [11:0] otw_o;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;
    longint track = 0;
    longint m_ref = 0, m_phe = 0, m_integ = 0, m_lf = 0, m_i0 = 0, m_i1 = 0;

    always #10 clk = ~clk;

    phase_loop_core dut_i (
        .clk         (clk),
        .rst         (rst),
        .fcw_i       (fcw_i),
        .osc_cnt_i   (osc_cnt_i),
        .tdc_code_i  (tdc_code_i),
        .kp_shift_i  (kp_shift_i),
        .ki_shift_i  (ki_shift_i),
        .int_en_i    (int_en_i),
        .iir_en_i    (iir_en_i),
        .iir_shift_i (iir_shift_i),
        .phase_err_o (phase_err_o),
        .otw_o       (otw_o)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint sat32(input longint v);
        if (v > 64'sd2147483647) return 64'sd2147483647;
        if (v < -64'sd2147483648) return -64'sd2147483648;
        return v;
    endfunction

    function automatic longint s24(input longint v);
        longint w;
        w = v & MASK;
        if (w >= 64'sd8388608) w = w - 64'sd16777216;
        return w;
    endfunction

    function automatic longint model_otw();
        longint t;
        t = (m_i1 >>> 8) + 2048;
        if (t < 0) t = 0;
        if (t > 4095) t = 4095;
        return t;
    endfunction

    task automatic model_reset();
        m_ref = 0; m_phe = 0; m_integ = 0; m_lf = 0; m_i0 = 0; m_i1 = 0; track = 0;
    endtask

    task automatic model_edge();
        longint osc, n_ref, n_phe, p, inc, isum, n_lf, n_integ, n_i0, n_i1;
        osc   = (longint'(osc_cnt_i) << 16) | (longint'(tdc_code_i) << 10);
        n_ref = (m_ref + longint'(fcw_i)) & MASK;
        n_phe = s24(n_ref - osc);
        p     = m_phe >>> kp_shift_i;
        inc   = m_phe >>> ki_shift_i;
        isum  = sat32(m_integ + inc);
        if (int_en_i) begin
            n_integ = isum;
            n_lf    = sat32(p + isum);
        end else begin
            n_integ = 0;
            n_lf    = p;
        end
        n_i0 = iir_en_i ? m_i0 + ((m_lf - m_i0) >>> iir_shift_i) : m_lf;
        n_i1 = iir_en_i ? m_i1 + ((m_i0 - m_i1) >>> iir_shift_i) : m_i0;
        m_ref = n_ref; m_phe = n_phe; m_integ = n_integ;
        m_lf = n_lf; m_i0 = n_i0; m_i1 = n_i1;
    endtask

    task automatic step(input logic [7:0] oc, input logic [5:0] td);
        osc_cnt_i  = oc;
        tdc_code_i = td;
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic step_track(input longint lag, input string tag);
        longint drive;
        track = (track + longint'(fcw_i)) & MASK;
        drive = (track - lag) & MASK;
        step(8'(drive >> 16), 6'((drive >> 10) & 63));
        check({tag, " phase_err"}, longint'($signed(phase_err_o)), m_phe);
        check({tag, " otw"}, longint'(otw_o), model_otw());
    endtask

    task automatic set_cfg(input logic [3:0] kp, input logic [3:0] ki,
                           input logic ie, input logic ee, input logic [2:0] sh);
        kp_shift_i = kp; ki_shift_i = ki; int_en_i = ie; iir_en_i = ee; iir_shift_i = sh;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset();
        check("R1 reset phase_err", longint'($signed(phase_err_o)), 0);
        check("R1 reset otw", longint'(otw_o), 2048);

        // R2 and R3: explicit phase error after one edge
        fcw_i = 24'h020000;
        set_cfg(4'd0, 4'd0, 1'b0, 1'b0, 3'd0);
        step(8'd1, 6'd32);
        check("R2 R3 first error 2.0-1.5", longint'($signed(phase_err_o)), 64'sh008000);

        // R8 latency and R5 proportional value: constant error of one cycle
        do_reset();
        fcw_i = 24'h010000;
        for (int k = 1; k <= 3; k++) begin
            step(8'(k - 1), 6'd0);
            check("R8 otw held before pipeline fills", longint'(otw_o), 2048);
        end
        step(8'd3, 6'd0);
        check("R8 otw due on fourth edge", longint'(otw_o), 2304);
        check("R5 error one cycle", longint'($signed(phase_err_o)), 65536);
        kp_shift_i = 4'd2;
        for (int k = 4; k < 9; k++) step(8'(k), 6'd0);
        check("R5 kp shift 2 value", longint'(otw_o), 2112);

        // Table-driven rows against the reference model
        do_reset();
        for (int r = 0; r < NROWS; r++) begin
            fcw_i = ROWS[r].fcw;
            set_cfg(ROWS[r].kp, ROWS[r].ki, ROWS[r].ie, ROWS[r].ee, ROWS[r].sh);
            for (int s = 0; s < int'(ROWS[r].steps); s++) begin
                step_track(s24(longint'(ROWS[r].lag)), $sformatf("R6 R7 row%0d", r));
                if (r == 0) begin
                    // R4 R9: tracking loop keeps zero error across integer wrap
                    check("R4 R9 lock error", longint'($signed(phase_err_o)), 0);
                    check("R9 lock otw", longint'(otw_o), 2048);
                end
            end
            if (r == 4) check("R8 saturate high", longint'(otw_o), 4095);
            if (r == 5) check("R8 saturate low", longint'(otw_o), 0);
        end

        // R1: mid-run reset clears accumulated state
        do_reset();
        check("R1 mid reset otw", longint'(otw_o), 2048);
        check("R1 mid reset phase_err", longint'($signed(phase_err_o)), 0);
        fcw_i = 24'h051000;
        step(8'd0, 6'd0);
        check("R1 R2 accumulator restarted", longint'($signed(phase_err_o)), 64'sh051000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule